// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Carry and Overflow Flags

This block is the add/subtract part of a 32-bit integer execution pipe. Each cycle it takes two register operands, a 16-bit immediate and an operation code, and forms a combinational sum from an adder with carry-in. Every subtract form is computed as the inverted first operand plus the second operand plus a carry-in. The operand forms cover plain add, add with the stored carry, add of all-ones or zero with the stored carry, the matching subtract-from forms, negate, and four immediate forms.

Three flag bits are registered: carry, overflow and a sticky summary overflow. A 4-bit condition field is also registered. Per-operation controls choose whether the carry is written, whether signed overflow is recorded, and whether the condition field takes a signed three-way compare of the result against zero. The flags and the condition field change only on a clock edge on which the operation strobe is high.

Top module: `int_addsub_unit`

## Requirements
- R1: The operation code selects a form. The encodings are 0 add, 1 add-carrying, 2 add-extended, 3 add-minus-one-extended, 4 add-zero-extended, 5 sub-from, 6 sub-from-carrying, 7 sub-from-extended, 8 sub-from-minus-one-extended, 9 sub-from-zero-extended, 10 negate, 11 add-immediate, 12 add-immediate-shifted, 13 add-immediate-carrying, 14 add-immediate-carrying-record, and 15 sub-from-immediate-carrying.
- R2: The add forms produce a+b (codes 0 and 1), a+b+CA (2), a+0xFFFFFFFF+CA (3) and a+CA (4), all modulo 2^32. CA is the stored carry flag.
- R3: The subtract-from forms produce ~a+b+1 (codes 5 and 6), ~a+b+CA (7), ~a+0xFFFFFFFF+CA (8) and ~a+CA (9). Negate produces ~a+1.
- R4: The non-shifted immediate forms sign-extend the 16-bit immediate. Code 12 adds the immediate shifted left by 16. Code 15 produces ~a+sext(imm)+1.
- R5: Codes 11 and 12 use zero in place of the first operand when the register-zero input is high. All other codes ignore that input.
- R6: Codes 1 to 4, 6 to 9 and 13 to 15 load the carry flag with the adder's carry-out from bit 31. Codes 0, 5, 10, 11 and 12 leave the carry flag unchanged.
- R7: When OE is high, the overflow flag takes the signed overflow of the sum. When OE is low, the overflow flag holds its value.
- R8: Summary overflow is set when OE is high and the sum overflows. It is never cleared except by reset.
- R9: When Rc is high, or for code 14, the condition field becomes 0x8 for a negative result, 0x4 for a positive result and 0x2 for a zero result. Otherwise the condition field holds its value.
- R10: The flags and the condition field change only on a clock edge with the operation strobe high. Reset clears all of them to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| op_valid | input | 1 | Strobe that lets the flags and condition field update |
| op_sel | input | 4 | Operation code (see R1) |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| imm | input | 16 | Immediate operand |
| a_is_r0 | input | 1 | First operand was register index zero |
| oe_en | input | 1 | Record signed overflow |
| rc_en | input | 1 | Write the condition field |
| result | output | 32 | Combinational sum |
| ca_flag | output | 1 | Registered carry flag |
| ov_flag | output | 1 | Registered overflow flag |
| so_flag | output | 1 | Registered sticky summary overflow |
| cond_field | output | 4 | Registered condition field |

## Verification
The hardest situations to reach from the ports depend on history. One is a summary overflow that must survive later overflow-free operations with OE high. The other is an extended form that consumes a carry left by an earlier operation several vectors back. Directed pairs drive the adder to signed overflow and then follow with clean operations. Random sequences keep every code in flight, so the extended forms see both carry values set by a range of earlier producers. A reference model in the bench tracks the carry, overflow, summary overflow and condition state across vectors.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,
    OP_ADDC   = 4'd1,
    OP_ADDE   = 4'd2,
    OP_ADDME  = 4'd3,
    OP_ADDZE  = 4'd4,
    OP_SUBF   = 4'd5,
    OP_SUBFC  = 4'd6,
    OP_SUBFE  = 4'd7,
    OP_SUBFME = 4'd8,
    OP_SUBFZE = 4'd9,
    OP_NEG    = 4'd10,
    OP_ADDI   = 4'd11,
    OP_ADDIS  = 4'd12,
    OP_ADDIC  = 4'd13,
    OP_ADDICR = 4'd14,
    OP_SUBFIC = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic ca;
    logic ov;
    logic so;
  } flags_t;

endpackage

// File: rtl/addsub_operands.sv
module addsub_operands
  import addsub_pkg::*;
#(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input  alu_op_e         op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [IW-1:0]   imm,
  input  logic            a_is_r0,
  input  logic            ca_in,
  output logic [W-1:0]    x,
  output logic [W-1:0]    y,
  output logic            cin,
  output logic            ca_wr,
  output logic            rc_force
);

  localparam int EXT = W - IW;

  logic [W-1:0] imm_sx;
  logic [W-1:0] imm_hi;
  logic [W-1:0] a_or_zero;

  assign imm_sx    = {{EXT{imm[IW-1]}}, imm};
  assign imm_hi    = W'(imm) << IW;
  assign a_or_zero = a_is_r0 ? '0 : a;

  always_comb begin
    x        = a;
    y        = b;
    cin      = 1'b0;
    ca_wr    = 1'b0;
    rc_force = 1'b0;
    unique case (op)
      OP_ADD:    begin end
      OP_ADDC:   ca_wr = 1'b1;
      OP_ADDE:   begin cin = ca_in; ca_wr = 1'b1; end
      OP_ADDME:  begin y = '1; cin = ca_in; ca_wr = 1'b1; end
      OP_ADDZE:  begin y = '0; cin = ca_in; ca_wr = 1'b1; end
      OP_SUBF:   begin x = ~a; cin = 1'b1; end
      OP_SUBFC:  begin x = ~a; cin = 1'b1; ca_wr = 1'b1; end
      OP_SUBFE:  begin x = ~a; cin = ca_in; ca_wr = 1'b1; end
      OP_SUBFME: begin x = ~a; y = '1; cin = ca_in; ca_wr = 1'b1; end
      OP_SUBFZE: begin x = ~a; y = '0; cin = ca_in; ca_wr = 1'b1; end
      OP_NEG:    begin x = ~a; y = '0; cin = 1'b1; end
      OP_ADDI:   begin x = a_or_zero; y = imm_sx; end
      OP_ADDIS:  begin x = a_or_zero; y = imm_hi; end
      OP_ADDIC:  begin y = imm_sx; ca_wr = 1'b1; end
      OP_ADDICR: begin y = imm_sx; ca_wr = 1'b1; rc_force = 1'b1; end
      OP_SUBFIC: begin x = ~a; y = imm_sx; cin = 1'b1; ca_wr = 1'b1; end
      default:   begin end
    endcase
  end

endmodule

// File: rtl/addsub_adder.sv
module addsub_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);

  logic [W:0] wide;

  assign wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  assign sum  = wide[W-1:0];
  assign cout = wide[W];
  assign ovf  = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);

endmodule

// File: rtl/addsub_cond.sv
module addsub_cond #(
  parameter int W = 32
) (
  input  logic [W-1:0] value,
  output logic [3:0]   nibble
);

  logic neg, zero, pos;

  assign neg    = value[W-1];
  assign zero   = (value == '0);
  assign pos    = !neg && !zero;
  assign nibble = {neg, pos, zero, 1'b0};

endmodule

// File: rtl/int_addsub_unit.sv
module int_addsub_unit
  import addsub_pkg::*;
#(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [3:0]    op_sel,
  input  logic [W-1:0]  src_a,
  input  logic [W-1:0]  src_b,
  input  logic [IW-1:0] imm,
  input  logic          a_is_r0,
  input  logic          oe_en,
  input  logic          rc_en,
  output logic [W-1:0]  result,
  output logic          ca_flag,
  output logic          ov_flag,
  output logic          so_flag,
  output logic [3:0]    cond_field
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  flags_t     flg_q, flg_d;
  logic [3:0] cond_q, cond_d;

  logic [W-1:0] opx, opy, sum;
  logic         cin, ca_wr, rc_force, cout, ovf;
  logic [3:0]   cmp_nib;

  addsub_operands #(.W(W), .IW(IW)) u_ops (
    .op       (alu_op_e'(op_sel)),
    .a        (src_a),
    .b        (src_b),
    .imm      (imm),
    .a_is_r0  (a_is_r0),
    .ca_in    (flg_q.ca),
    .x        (opx),
    .y        (opy),
    .cin      (cin),
    .ca_wr    (ca_wr),
    .rc_force (rc_force)
  );

  addsub_adder #(.W(W)) u_add (
    .x    (opx),
    .y    (opy),
    .cin  (cin),
    .sum  (sum),
    .cout (cout),
    .ovf  (ovf)
  );

  addsub_cond #(.W(W)) u_cmp (
    .value  (sum),
    .nibble (cmp_nib)
  );

  always_comb begin
    flg_d  = flg_q;
    cond_d = cond_q;
    if (ca_wr)          flg_d.ca = cout;
    if (oe_en)          flg_d.ov = ovf;
    if (oe_en && ovf)   flg_d.so = 1'b1;
    if (rc_en || rc_force) cond_d = cmp_nib;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      flg_q  <= '0;
      cond_q <= '0;
    end else if (op_valid) begin
      flg_q  <= flg_d;
      cond_q <= cond_d;
    end
  end

  assign result     = sum;
  assign ca_flag    = flg_q.ca;
  assign ov_flag    = flg_q.ov;
  assign so_flag    = flg_q.so;
  assign cond_field = cond_q;

endmodule

// File: rtl/int_addsub_unit_chk.sv
module int_addsub_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [3:0]  op_sel,
  input logic        oe_en,
  input logic        rc_en,
  input logic        ca_flag,
  input logic        ov_flag,
  input logic        so_flag,
  input logic [3:0]  cond_field
);

  logic no_ca_op;
  assign no_ca_op = (op_sel == 4'd0) || (op_sel == 4'd5) || (op_sel == 4'd10) ||
                    (op_sel == 4'd11) || (op_sel == 4'd12);

  AST_SO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    so_flag |=> so_flag);  // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable({ca_flag, ov_flag, so_flag, cond_field}));  // R10

  AST_CARRY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && no_ca_op) |=> $stable(ca_flag));  // R6

  AST_OV_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !oe_en) |=> $stable(ov_flag));  // R7

  AST_COND_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (rc_en || op_sel == 4'd14)) |=> ($countones(cond_field) == 1));  // R9

  AST_OV_TO_SO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ov_flag) |-> so_flag);  // R8

endmodule

bind int_addsub_unit int_addsub_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .op_sel     (op_sel),
  .oe_en      (oe_en),
  .rc_en      (rc_en),
  .ca_flag    (ca_flag),
  .ov_flag    (ov_flag),
  .so_flag    (so_flag),
  .cond_field (cond_field)
);

// File: tb/sim_int_addsub_unit.sv
`timescale 1ns/1ps
module sim_int_addsub_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  op_sel;
  logic [31:0] src_a, src_b;
  logic [15:0] imm;
  logic        a_is_r0, oe_en, rc_en;
  logic [31:0] result;
  logic        ca_flag, ov_flag, so_flag;
  logic [3:0]  cond_field;

  int n_chk = 0;
  int n_bad = 0;

  logic       m_ca, m_ov, m_so;
  logic [3:0] m_cond;

  always #2.5 clk = ~clk;

  int_addsub_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .src_a(src_a), .src_b(src_b), .imm(imm), .a_is_r0(a_is_r0),
    .oe_en(oe_en), .rc_en(rc_en), .result(result), .ca_flag(ca_flag),
    .ov_flag(ov_flag), .so_flag(so_flag), .cond_field(cond_field)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // operand forms from R2..R5; returns {x,y,cin}
  function automatic logic [64:0] ref_ops(input logic [3:0] op, input logic [31:0] a,
      input logic [31:0] b, input logic [15:0] i, input logic r0, input logic ca);
    logic [31:0] sx, az;
    sx = {{16{i[15]}}, i};
    az = r0 ? 32'd0 : a;
    case (op)
      4'd0, 4'd1: return {a, b, 1'b0};
      4'd2:  return {a, b, ca};
      4'd3:  return {a, 32'hFFFF_FFFF, ca};
      4'd4:  return {a, 32'd0, ca};
      4'd5, 4'd6: return {~a, b, 1'b1};
      4'd7:  return {~a, b, ca};
      4'd8:  return {~a, 32'hFFFF_FFFF, ca};
      4'd9:  return {~a, 32'd0, ca};
      4'd10: return {~a, 32'd0, 1'b1};
      4'd11: return {az, sx, 1'b0};
      4'd12: return {az, {i, 16'd0}, 1'b0};
      4'd13, 4'd14: return {a, sx, 1'b0};
      default: return {~a, sx, 1'b1};
    endcase
  endfunction

  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
      input logic [15:0] i, input logic r0, input logic oe, input logic rc, input logic v);
    logic [64:0] o;
    logic [32:0] w;
    logic ov, writes_ca;
    @(negedge clk);
    op_sel = op; src_a = a; src_b = b; imm = i; a_is_r0 = r0;
    oe_en = oe; rc_en = rc; op_valid = v;
    o = ref_ops(op, a, b, i, r0, m_ca);
    w = {1'b0, o[64:33]} + {1'b0, o[32:1]} + {32'd0, o[0]};
    ov = (o[64] == o[32]) && (w[31] != o[64]);
    #1;
    if (op <= 4'd4)       check("R2 add result", result, w[31:0]);
    else if (op <= 4'd10) check("R3 subtract result", result, w[31:0]);
    else if (r0)          check("R5 index-zero result", result, w[31:0]);
    else                  check("R4 immediate result", result, w[31:0]);
    writes_ca = !(op == 4'd0 || op == 4'd5 || op == 4'd10 || op == 4'd11 || op == 4'd12);
    if (v) begin
      if (writes_ca) m_ca = w[32];
      if (oe) m_ov = ov;
      if (oe && ov) m_so = 1'b1;
      if (rc || op == 4'd14)
        m_cond = w[31] ? 4'h8 : (w[31:0] == 0) ? 4'h2 : 4'h4;
    end
    @(posedge clk); #1;
    check(v ? "R6 carry flag" : "R10 idle carry", {31'd0, ca_flag}, {31'd0, m_ca});
    check(v ? "R7 overflow flag" : "R10 idle overflow", {31'd0, ov_flag}, {31'd0, m_ov});
    check(v ? "R8 summary overflow" : "R10 idle summary", {31'd0, so_flag}, {31'd0, m_so});
    check(v ? "R9 condition field" : "R10 idle condition", {28'd0, cond_field}, {28'd0, m_cond});
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd1234);
    m_ca = 0; m_ov = 0; m_so = 0; m_cond = 0;
    rst_n = 0; op_valid = 0; op_sel = 0; src_a = 0; src_b = 0; imm = 0;
    a_is_r0 = 0; oe_en = 0; rc_en = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset flags", {29'd0, ca_flag, ov_flag, so_flag}, 32'd0);
    check("R10 reset cond", {28'd0, cond_field}, 32'd0);

    // R1 each code once
    for (int k = 0; k < 16; k++)
      apply(4'(k), 32'h1234_5678, 32'h8765_4321, 16'h8001, 1'b0, 1'b0, 1'b1, 1'b1);
    // R2 carry chain: make carry 1 then consume
    apply(4'd1, 32'hFFFF_FFFF, 32'd1, 16'd0, 0, 0, 1, 1);
    apply(4'd2, 32'd5, 32'd6, 16'd0, 0, 0, 1, 1);
    apply(4'd3, 32'd0, 32'd0, 16'd0, 0, 0, 1, 1);
    apply(4'd4, 32'hFFFF_FFFF, 32'd0, 16'd0, 0, 0, 1, 1);
    // R3 negate of minimum, subfe with carry
    apply(4'd10, 32'h8000_0000, 32'd0, 16'd0, 0, 1, 1, 1);
    apply(4'd7, 32'd3, 32'd3, 16'd0, 0, 0, 1, 1);
    // R8 overflow then clean OE op: summary stays
    apply(4'd0, 32'h7FFF_FFFF, 32'd1, 16'd0, 0, 1, 1, 1);
    apply(4'd0, 32'd1, 32'd1, 16'd0, 0, 1, 1, 1);
    apply(4'd5, 32'd1, 32'd1, 16'd0, 0, 1, 1, 1);
    // R7 OE low holds overflow
    apply(4'd0, 32'h7FFF_FFFF, 32'd1, 16'd0, 0, 1, 0, 1);
    apply(4'd0, 32'd1, 32'd1, 16'd0, 0, 0, 0, 1);
    // R5 index zero on ADDI/ADDIS and ignored on ADDIC
    apply(4'd11, 32'hDEAD_BEEF, 32'd0, 16'hFFFE, 1, 0, 1, 1);
    apply(4'd12, 32'hDEAD_BEEF, 32'd0, 16'h8000, 1, 0, 1, 1);
    apply(4'd13, 32'h0000_0002, 32'd0, 16'hFFFE, 1, 0, 1, 1);
    // R4 subfic and sign extension
    apply(4'd15, 32'd10, 32'd0, 16'd10, 0, 0, 1, 1);
    apply(4'd14, 32'd0, 32'd0, 16'h8000, 0, 0, 0, 1);
    // R10 strobe low: nothing changes
    apply(4'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'd0, 0, 1, 1, 0);

    // reset clears summary overflow
    rst_n = 0; #1; m_ca = 0; m_ov = 0; m_so = 0; m_cond = 0;
    repeat (2) @(posedge clk); #1 rst_n = 1;
    repeat (3) @(posedge clk); #1;
    check("R10 reset after sticky", {29'd0, ca_flag, ov_flag, so_flag}, 32'd0);

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [31:0] ra, rb;
      int sel;
      sel = $urandom % 4;
      ra = (sel == 0) ? 32'h7FFF_FFFF : (sel == 1) ? 32'h8000_0000 : $urandom;
      rb = ($urandom % 3 == 0) ? ~ra : $urandom;
      apply(4'($urandom), ra, rb, 16'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), ($urandom % 8) != 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule